// File: doc/BRIEF.md
# Vector Lane Lookup-Table Unit

This block holds a private 1024-byte table that the lanes of a vector datapath read and write through per-lane indices. A command supplies an opcode (table read or table write), an access-size code, sixteen lane indices and sixteen lane write values. Each lane's index is scaled by the access size (1, 2 or 4 bytes) to form a byte address. A read returns the addressed entry to that lane's result. A write stores the lane's value at the addressed entry.

The unit serves one lane per clock cycle, from lane 0 up to lane 15, under a start/busy/done handshake. The controller is a three-state machine. ST_IDLE waits for `start`. A well-formed command moves it from ST_IDLE to ST_SWEEP. Any other command moves it from ST_IDLE straight to ST_FINISH. ST_SWEEP stays in ST_SWEEP while lanes remain, and moves to ST_FINISH after lane 15. ST_FINISH always returns to ST_IDLE. `busy` is high in ST_SWEEP and ST_FINISH. `done` is high only in ST_FINISH.

Top module: `vlut_unit`

## Requirements
- R1: After reset `busy`, `done` and every lane result are zero, and every table byte reads as zero.
- R2: A table read or table write accepted in ST_IDLE raises `busy` after that clock edge. `done` is high for exactly one cycle, 17 cycles after the accepting edge. `busy` falls with `done`.
- R3: On a read (opcode 5'b01000), lane i's result becomes the entry at byte address `index[i]*size`, zero-extended to 32 bits. Results stay stable once `done` is seen.
- R4: On a write (opcode 5'b01001), the low `size` bytes of lane i's write value are stored at byte address `index[i]*size`, least significant byte at the lowest address.
- R5: Size code 2'b00 selects 1-byte entries, 2'b01 selects 2-byte entries and 2'b10 selects 4-byte entries. Entries of different sizes overlap the same bytes.
- R6: Size code 2'b11 is a no-operation. It leaves the table and lane results unchanged, and `done` rises one cycle after the accepting edge.
- R7: Any opcode other than 5'b01000 and 5'b01001 is a no-operation with the same timing as R6.
- R8: The byte address is reduced modulo 1024, so large indices wrap around the table.
- R9: Lanes are serviced in ascending order, one per cycle. When several lanes write the same entry, the highest-numbered lane's value remains.
- R10: `start` is ignored while `busy` is high.
- R11: Opcode, size code, indices and write data are captured at the accepting edge. Changes to these inputs during `busy` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command request, sampled in ST_IDLE |
| opcode | input | 5 | Operation code (read 5'b01000, write 5'b01001) |
| size_code | input | 2 | Access size code |
| lane_index | input | 256 | Sixteen 16-bit lane indices, lane 0 in the low bits |
| lane_wdata | input | 512 | Sixteen 32-bit lane write values, lane 0 in the low bits |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| lane_rdata | output | 512 | Sixteen 32-bit lane read results, lane 0 in the low bits |

## Verification
The hardest situation to reach from the ports is a conflict inside one command. Either several lanes hit the same entry, or the inputs move while a sweep is running. The stimulus builds commands in which all sixteen lanes write one 2-byte entry with different data, then reads that entry back. In another command, `start` is pulsed again mid-sweep while the index and data buses are scrambled. The reference model compares the busy/done schedule on every cycle and compares every lane result at completion.

// File: rtl/vlut_pkg.sv
package vlut_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SWEEP  = 2'd1,
        ST_FINISH = 2'd2
    } vlut_state_e;

    localparam logic [4:0] OPC_TBL_READ  = 5'b01000;
    localparam logic [4:0] OPC_TBL_WRITE = 5'b01001;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;
    localparam logic [1:0] SZ_WORD = 2'b10;
    localparam logic [1:0] SZ_NONE = 2'b11;

    // byte-lane enable mask for a given size code
    function automatic logic [3:0] size_mask(input logic [1:0] code);
        logic [3:0] m;
        unique case (code)
            SZ_BYTE: m = 4'b0001;
            SZ_HALF: m = 4'b0011;
            SZ_WORD: m = 4'b1111;
            default: m = 4'b0000;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/vlut_ctrl.sv
module vlut_ctrl
    import vlut_pkg::*;
#(
    parameter int LANES  = 16,
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cmd_ok,
    output logic              accept,
    output logic              step,
    output logic [LANE_W-1:0] lane,
    output logic              busy,
    output logic              done
);

    vlut_state_e state, state_nx;
    logic        last_lane;

    assign last_lane = (lane == LANE_W'(LANES - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nx = cmd_ok ? ST_SWEEP : ST_FINISH;
                end
            end
            ST_SWEEP: begin
                if (last_lane) begin
                    state_nx = ST_FINISH;
                end
            end
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept = 1'b0;
        step   = 1'b0;
        busy   = 1'b0;
        done   = 1'b0;
        unique case (state)
            ST_IDLE:   accept = start;
            ST_SWEEP:  begin step = 1'b1; busy = 1'b1; end
            ST_FINISH: begin busy = 1'b1; done = 1'b1; end
            default:   ;
        endcase
    end

    // lane counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane <= '0;
        end else if (accept) begin
            lane <= '0;
        end else if (step && !last_lane) begin
            lane <= lane + LANE_W'(1);
        end
    end

    assert_lane_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWEEP && !last_lane) |=> (lane == $past(lane) + LANE_W'(1)));

    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWEEP && !last_lane && start) |=> (state == ST_SWEEP));

    assert_noop_fast_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cmd_ok) |=> done);

endmodule

// File: rtl/vlut_addr.sv
module vlut_addr
    import vlut_pkg::*;
#(
    parameter int LANES  = 16,
    parameter int IDX_W  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 10,
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [LANES*IDX_W-1:0]  idx_bus,
    input  logic [LANES*DATA_W-1:0] wdata_bus,
    input  logic [LANE_W-1:0]       lane,
    input  logic [1:0]              size,
    output logic [ADDR_W-1:0]       byte_addr,
    output logic [DATA_W-1:0]       lane_wdata
);

    logic [IDX_W-1:0] lane_idx;
    logic [IDX_W+1:0] scaled;

    always_comb begin
        lane_idx   = idx_bus[lane*IDX_W +: IDX_W];
        lane_wdata = wdata_bus[lane*DATA_W +: DATA_W];
        unique case (size)
            SZ_HALF: scaled = {1'b0, lane_idx, 1'b0};
            SZ_WORD: scaled = {lane_idx, 2'b00};
            default: scaled = {2'b00, lane_idx};
        endcase
        // wrap modulo the table size (R8)
        byte_addr = scaled[ADDR_W-1:0];
    end

endmodule

// File: rtl/vlut_store.sv
module vlut_store
    import vlut_pkg::*;
#(
    parameter int TABLE_BYTES = 1024,
    localparam int ADDR_W     = $clog2(TABLE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata
);

    logic [7:0]        bytes_q [TABLE_BYTES];
    logic [3:0]        mask;
    logic [ADDR_W-1:0] baddr [4];

    assign mask = size_mask(size);

    for (genvar k = 0; k < 4; k++) begin : g_byte
        assign baddr[k] = addr + ADDR_W'(k);
        assign rdata[8*k +: 8] = mask[k] ? bytes_q[baddr[k]] : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < TABLE_BYTES; j++) begin
                bytes_q[j] <= 8'h00;
            end
        end else if (wr_en) begin
            for (int k = 0; k < 4; k++) begin
                if (mask[k]) begin
                    bytes_q[baddr[k]] <= wdata[8*k +: 8];
                end
            end
        end
    end

    assert_aligned_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && size == SZ_WORD) |-> (addr[1:0] == 2'b00));

    assert_half_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && size == SZ_HALF) |-> (addr[0] == 1'b0));

endmodule

// File: rtl/vlut_unit.sv
module vlut_unit
    import vlut_pkg::*;
#(
    parameter int LANES       = 16,
    parameter int IDX_W       = 16,
    parameter int TABLE_BYTES = 1024,
    localparam int DATA_W     = 32,
    localparam int ADDR_W     = $clog2(TABLE_BYTES),
    localparam int LANE_W     = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [4:0]              opcode,
    input  logic [1:0]              size_code,
    input  logic [LANES*IDX_W-1:0]  lane_index,
    input  logic [LANES*DATA_W-1:0] lane_wdata,
    output logic                    busy,
    output logic                    done,
    output logic [LANES*DATA_W-1:0] lane_rdata
);

    logic                    cmd_ok, accept, step;
    logic [LANE_W-1:0]       lane;
    logic                    is_write_q;
    logic [1:0]              size_q;
    logic [LANES*IDX_W-1:0]  idx_q;
    logic [LANES*DATA_W-1:0] wdata_q;
    logic [ADDR_W-1:0]       byte_addr;
    logic [DATA_W-1:0]       cur_wdata, cur_rdata;
    logic [DATA_W-1:0]       res_q [LANES];

    assign cmd_ok = ((opcode == OPC_TBL_READ) || (opcode == OPC_TBL_WRITE))
                    && (size_code != SZ_NONE);

    vlut_ctrl #(.LANES(LANES)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .cmd_ok (cmd_ok),
        .accept (accept),
        .step   (step),
        .lane   (lane),
        .busy   (busy),
        .done   (done)
    );

    // operand capture (R11)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_write_q <= 1'b0;
            size_q     <= SZ_NONE;
            idx_q      <= '0;
            wdata_q    <= '0;
        end else if (accept && cmd_ok) begin
            is_write_q <= (opcode == OPC_TBL_WRITE);
            size_q     <= size_code;
            idx_q      <= lane_index;
            wdata_q    <= lane_wdata;
        end
    end

    vlut_addr #(
        .LANES  (LANES),
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_addr (
        .idx_bus    (idx_q),
        .wdata_bus  (wdata_q),
        .lane       (lane),
        .size       (size_q),
        .byte_addr  (byte_addr),
        .lane_wdata (cur_wdata)
    );

    vlut_store #(.TABLE_BYTES(TABLE_BYTES)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (step && is_write_q),
        .size  (size_q),
        .addr  (byte_addr),
        .wdata (cur_wdata),
        .rdata (cur_rdata)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_q[i] <= '0;
            end else if (step && !is_write_q && lane == LANE_W'(i)) begin
                res_q[i] <= cur_rdata;
            end
        end
        assign lane_rdata[i*DATA_W +: DATA_W] = res_q[i];
    end

    assert_operands_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(idx_q) && $stable(wdata_q) && $stable(size_q)));

    assert_result_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(lane_rdata));

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(accept && cmd_ok)) |=> $stable(lane_rdata));

endmodule

// File: tb/sim_vlut_unit.sv
module sim_vlut_unit;

    localparam int NL = 16;
    localparam logic [4:0] RD = 5'b01000;
    localparam logic [4:0] WR = 5'b01001;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [4:0]    opcode = '0;
    logic [1:0]    size_code = '0;
    logic [255:0]  lane_index = '0;
    logic [511:0]  lane_wdata = '0;
    logic          busy, done;
    logic [511:0]  lane_rdata;

    int total = 0;
    int bad = 0;

    logic [7:0]  tbl [1024];
    logic [31:0] exp_rd [NL];
    logic [15:0] idx [NL];
    logic [31:0] wd [NL];

    always #4 clk = ~clk;

    vlut_unit u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .opcode     (opcode),
        .size_code  (size_code),
        .lane_index (lane_index),
        .lane_wdata (lane_wdata),
        .busy       (busy),
        .done       (done),
        .lane_rdata (lane_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model(input logic [4:0] op, input logic [1:0] w);
        int nb;
        nb = 1 << w;
        for (int l = 0; l < NL; l++) begin
            int a;
            logic [31:0] v;
            a = (int'(idx[l]) * nb) % 1024;
            if (op == WR) begin
                for (int k = 0; k < nb; k++) tbl[(a + k) % 1024] = wd[l][8*k +: 8];
            end else begin
                v = '0;
                for (int k = 0; k < nb; k++) v[8*k +: 8] = tbl[(a + k) % 1024];
                exp_rd[l] = v;
            end
        end
    endtask

    task automatic run_op(input logic [4:0] op, input logic [1:0] w,
                          input bit disturb, input string tag);
        bit valid;
        int n;
        valid = (op == RD || op == WR) && (w != 2'b11);
        n = valid ? 17 : 1;
        @(negedge clk);
        opcode = op;
        size_code = w;
        for (int l = 0; l < NL; l++) begin
            lane_index[16*l +: 16] = idx[l];
            lane_wdata[32*l +: 32] = wd[l];
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (valid) model(op, w);
        for (int k = 1; k <= n; k++) begin
            chk(busy == 1'b1, $sformatf("R2 busy cycle %0d %s", k, tag), 32'(busy), 32'd1);
            chk(done == (k == n), $sformatf("R2 done cycle %0d %s", k, tag),
                32'(done), 32'(k == n));
            if (disturb && k == 3) begin
                start = 1'b1;
                opcode = WR;
                size_code = 2'b00;
                lane_index = ~lane_index;
                lane_wdata = ~lane_wdata;
            end
            if (disturb && k == 4) start = 1'b0;
            @(negedge clk);
        end
        chk(busy == 1'b0 && done == 1'b0, $sformatf("R2 idle after %s", tag),
            {30'd0, busy, done}, 32'd0);
        for (int l = 0; l < NL; l++) begin
            chk(lane_rdata[32*l +: 32] === exp_rd[l],
                $sformatf("%s lane %0d", tag, l), lane_rdata[32*l +: 32], exp_rd[l]);
        end
    endtask

    initial begin
        #(8 * 200000);
        total++;
        bad++;
        $display("FAIL R2 watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int j = 0; j < 1024; j++) tbl[j] = 8'h00;
        for (int l = 0; l < NL; l++) exp_rd[l] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0 && done == 1'b0, "R1 handshake at reset", {30'd0, busy, done}, 32'd0);
        chk(lane_rdata == '0, "R1 results at reset", lane_rdata[31:0], 32'd0);
        rst_n = 1'b1;

        // R1: table cleared
        for (int l = 0; l < NL; l++) idx[l] = 16'(l * 7);
        run_op(RD, 2'b10, 1'b0, "R1 table zero");

        // R4 then R3: 32-bit write and read back
        for (int l = 0; l < NL; l++) begin
            idx[l] = 16'(l);
            wd[l] = $urandom;
        end
        run_op(WR, 2'b10, 1'b0, "R4 word write");
        run_op(RD, 2'b10, 1'b0, "R3 word read");

        // R5: byte writes, read as halves and words (little-endian, zero-extend)
        for (int l = 0; l < NL; l++) begin
            idx[l] = 16'(64 + l);
            wd[l] = 32'hCC00_00A0 + 32'(l);
        end
        run_op(WR, 2'b00, 1'b0, "R5 byte write");
        for (int l = 0; l < NL; l++) idx[l] = 16'(32 + (l % 8));
        run_op(RD, 2'b01, 1'b0, "R5 half read");
        for (int l = 0; l < NL; l++) idx[l] = 16'(16 + (l % 4));
        run_op(RD, 2'b10, 1'b0, "R5 word read");
        for (int l = 0; l < NL; l++) begin
            idx[l] = 16'(40 + l);
            wd[l] = 32'hBEEF_0000 | 32'(l * 3);
        end
        run_op(WR, 2'b01, 1'b0, "R5 half write");
        for (int l = 0; l < NL; l++) idx[l] = 16'(80 + l);
        run_op(RD, 2'b00, 1'b0, "R5 byte read");

        // R8: wrap modulo 1024
        for (int l = 0; l < NL; l++) begin
            idx[l] = 16'(256 + 200 + l);
            wd[l] = 32'h1234_0000 + 32'(l);
        end
        run_op(WR, 2'b10, 1'b0, "R8 wrapped write");
        for (int l = 0; l < NL; l++) idx[l] = 16'(200 + l + ((l % 2) * 512));
        run_op(RD, 2'b10, 1'b0, "R8 wrapped read");
        for (int l = 0; l < NL; l++) idx[l] = 16'(1024 * (l % 4) + 800 + l);
        run_op(RD, 2'b00, 1'b0, "R8 byte wrap read");

        // R9: all lanes write one entry, highest lane wins
        for (int l = 0; l < NL; l++) begin
            idx[l] = 16'd5;
            wd[l] = 32'h0000_7700 + 32'(l);
        end
        run_op(WR, 2'b01, 1'b0, "R9 collide write");
        run_op(RD, 2'b01, 1'b0, "R9 collide read");

        // R6: size code 11 is a no-op
        for (int l = 0; l < NL; l++) begin
            idx[l] = 16'(l);
            wd[l] = 32'hFFFF_FFFF;
        end
        run_op(WR, 2'b11, 1'b0, "R6 noop write");
        run_op(RD, 2'b11, 1'b0, "R6 noop read keeps results");
        run_op(RD, 2'b10, 1'b0, "R6 table unchanged");

        // R7: unknown opcodes are no-ops
        run_op(5'b00000, 2'b10, 1'b0, "R7 opcode 00000");
        run_op(5'b01010, 2'b00, 1'b0, "R7 opcode 01010");
        run_op(RD, 2'b10, 1'b0, "R7 table unchanged");

        // R10 and R11: start pulse and input changes during a sweep
        for (int l = 0; l < NL; l++) begin
            idx[l] = 16'(100 + l);
            wd[l] = $urandom;
        end
        run_op(WR, 2'b10, 1'b1, "R10 R11 disturbed write");
        run_op(RD, 2'b10, 1'b1, "R10 R11 disturbed read");
        for (int l = 0; l < NL; l++) idx[l] = ~idx[l];
        run_op(RD, 2'b00, 1'b0, "R11 scrambled targets untouched");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule